// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block removes glitches from a bank of general-purpose trigger inputs before they reach the rest of the chip. Every raw input goes through a two-flop synchronizer. Its synchronized level is then sampled on the enable pulses of a filter tick that is divided down from the system timebase. The filtered output adopts a new level only once that level has been seen on N consecutive ticks. Any sample back at the old level clears the run, so a pulse shorter than N tick periods never appears at the output. Rising and falling edges are treated alike. The price is one tick period of jitter on the edge that does get through.

A small configuration interface selects the behaviour. It has a filter enable, a two-bit setting code, a custom tick divider and a custom sample count. Three presets pair a tick rate with a count:

- Fast: a tick on every cycle with a short count.
- Mid: a tick on every cycle with a long count.
- Slow: a tick every `HIGH_DIV` cycles with a mid-sized count.

The custom code takes its divider and count from the interface. Out of reset the filter is off and the synchronized input passes straight to the output register. Enabling the filter, or changing any setting while it is on, restarts the tick divider and the per-input run counters. It also loads each output with the current synchronized level, so no false edge appears.

Top module: `gf_glitch_filter`

## Requirements
- R1: While filtering with tick divider D = 1, an input step held steady changes `pin_out` exactly N+2 clock edges after the step (two synchronizer stages plus N tick samples). A single tick sample at the old level clears the run, so N more new-level samples are needed.
- R2: Falling transitions are filtered with the same count and latency as rising transitions.
- R3: Setting code 0 (fast) gives a tick on every cycle and N = `SHORT_CNT` (default 9). A pulse of 9 cycles passes and a pulse of 8 cycles is blocked.
- R4: Setting code 1 (mid) gives a tick on every cycle and N = `MED_CNT` (default 512). A pulse of 512 cycles passes and a pulse of 511 cycles is blocked.
- R5: Setting code 2 (slow) gives a tick every `HIGH_DIV` cycles (D) and N = `HIGH_CNT` (default 256). After a held step, `pin_out` is still at the old level at edge (N-1)·D+2 and at the new level by edge N·D+2. A pulse of (N-1)·D cycles is blocked and a pulse of N·D cycles passes.
- R6: Setting code 3 (custom) takes D from `cfg_div` and N from `cfg_count`, and a value of 0 in either field acts as 1. The same output window as in R5 applies.
- R7: After reset the filter is disabled and `pin_out` is 0. While disabled, `pin_out` follows `pin_in` three clock edges later.
- R8: Raising `cfg_enable`, or changing `cfg_mode`, `cfg_div` or `cfg_count` while enabled, clears the run counts. At that same edge it also sets `pin_out` to the synchronized input level, with no intermediate toggle.
- R9: Each input bit is filtered independently with its own counter, and all bits share one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | 1 = filter active, 0 = synchronized bypass |
| cfg_mode | input | 2 | Setting code: 0 fast, 1 mid, 2 slow, 3 custom |
| cfg_div | input | DIV_W | Custom tick divider (0 treated as 1) |
| cfg_count | input | CNT_W | Custom sample count N (0 treated as 1) |
| pin_in | input | NUM_IN | Raw asynchronous trigger inputs |
| pin_out | output | NUM_IN | Filtered, registered trigger outputs |

## Verification
A run counter that is stuck or cleared wrongly shows up as an output edge that comes early, late, or not at all. The bench measures each edge against a window one tick period wide: one edge early with D = 1, and one tick early or late for the slow preset. A divider that runs at the wrong rate stretches or shrinks that window by whole multiples of D, so it is caught on the first filtered edge. A reload that fails to load the output shows up at the next clock edge as a false level. Pulse tests placed exactly one tick below and at the threshold catch an off-by-one in the count comparison.

// File: rtl/gf_pkg.sv
package gf_pkg;

  typedef enum logic [1:0] {
    GF_FAST   = 2'd0,
    GF_MID    = 2'd1,
    GF_SLOW   = 2'd2,
    GF_CUSTOM = 2'd3
  } gf_mode_e;

  // Zero in a divider or count field means one.
  function automatic int unsigned gf_at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Select the value for the active setting.
  function automatic int unsigned gf_pick(input gf_mode_e m,
                                          input int unsigned fast_v,
                                          input int unsigned mid_v,
                                          input int unsigned slow_v,
                                          input int unsigned custom_v);
    case (m)
      GF_FAST: return fast_v;
      GF_MID:  return mid_v;
      GF_SLOW: return slow_v;
      default: return gf_at_least_one(custom_v);
    endcase
  endfunction

endpackage

// File: rtl/gf_tick_gen.sv
module gf_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last_phase;

  assign last_phase = div - 1'b1;
  assign tick = (phase_q >= last_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else              phase_q <= phase_q + 1'b1;
  end

  // R6
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_q == '0));

  // R3
  unit_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div == 1) |-> tick);
endmodule

// File: rtl/gf_lane.sv
module gf_lane #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             reload,
  input  logic             tick,
  input  logic [CNT_W-1:0] need,
  input  logic             din,
  output logic             dout
);
  logic [CNT_W-1:0] run_q;
  logic             out_q;
  logic [CNT_W:0]   run_inc;
  logic             differs;
  logic             hit;
  logic             settle;
  logic             miss;

  assign run_inc = {1'b0, run_q} + 1'b1;
  assign differs = (din != out_q);
  assign hit     = enable && !reload && tick && differs;
  assign settle  = hit && (run_inc >= {1'b0, need});
  assign miss    = enable && !reload && tick && !differs;
  assign dout    = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      out_q <= 1'b0;
    end else if (!enable || reload) begin
      run_q <= '0;
      out_q <= din;
    end else if (settle) begin
      run_q <= '0;
      out_q <= din;
    end else if (hit) begin
      run_q <= run_inc[CNT_W-1:0];
    end else if (miss) begin
      run_q <= '0;
    end
  end

  // R1
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !reload && !tick) |=> $stable(out_q));

  // R1
  restart_on_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (run_q == '0));

  // R1
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && enable) |-> (run_q < need));

  // R7
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (out_q == $past(din)));
endmodule

// File: rtl/gf_glitch_filter.sv
module gf_glitch_filter
  import gf_pkg::*;
#(
  parameter int NUM_IN    = 4,
  parameter int CNT_W     = 16,
  parameter int DIV_W     = 16,
  parameter int SHORT_CNT = 9,
  parameter int MED_CNT   = 512,
  parameter int HIGH_CNT  = 256,
  parameter int HIGH_DIV  = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [NUM_IN-1:0] pin_in,
  output logic [NUM_IN-1:0] pin_out
);
  localparam int unsigned UNIT = 1;

  gf_mode_e         mode_e;
  logic [DIV_W-1:0] div_eff;
  logic [CNT_W-1:0] need_eff;

  assign mode_e   = gf_mode_e'(cfg_mode);
  assign div_eff  = DIV_W'(gf_pick(mode_e, UNIT, UNIT, HIGH_DIV, 32'(cfg_div)));
  assign need_eff = CNT_W'(gf_pick(mode_e, SHORT_CNT, MED_CNT, HIGH_CNT, 32'(cfg_count)));

  // Configuration history for reload detection.
  logic             en_q;
  logic [1:0]       mode_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] count_q;
  logic             cfg_moved;
  logic             reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= '0;
      div_q   <= '0;
      count_q <= '0;
    end else begin
      en_q    <= cfg_enable;
      mode_q  <= cfg_mode;
      div_q   <= cfg_div;
      count_q <= cfg_count;
    end
  end

  assign cfg_moved = (cfg_mode != mode_q) || (cfg_div != div_q) || (cfg_count != count_q);
  assign reload    = cfg_enable && (!en_q || cfg_moved);

  // Two-stage synchronizer.
  logic [NUM_IN-1:0] meta_q;
  logic [NUM_IN-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  logic tick;

  gf_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (reload),
    .div     (div_eff),
    .tick    (tick)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    gf_lane #(.CNT_W(CNT_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (cfg_enable),
      .reload (reload),
      .tick   (tick),
      .need   (need_eff),
      .din    (sync_q[i]),
      .dout   (pin_out[i])
    );
  end

  // R8
  reload_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (pin_out == $past(sync_q)));

  // R6
  need_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (need_eff != '0) && (div_eff != '0));
endmodule

// File: tb/gf_glitch_filter_bench.sv
module gf_glitch_filter_bench;
  localparam int NUM_IN = 2;
  localparam int HDIV   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_enable = 1'b0;
  logic [1:0]        cfg_mode = 2'd0;
  logic [15:0]       cfg_div = 16'd1;
  logic [15:0]       cfg_count = 16'd1;
  logic [NUM_IN-1:0] pin_in = '0;
  logic [NUM_IN-1:0] pin_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gf_glitch_filter #(.NUM_IN(NUM_IN), .HIGH_DIV(HDIV)) u_gf_glitch_filter (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .cfg_div(cfg_div), .cfg_count(cfg_count), .pin_in(pin_in), .pin_out(pin_out)
  );

  task automatic check(input string tag, input logic [NUM_IN-1:0] got, input logic [NUM_IN-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic drive(input logic v);
    pin_in = {NUM_IN{v}};
  endtask

  // Pulse of len cycles from a quiet low level; report whether output ever rose.
  task automatic pulse(input string tag, input int len, input int mon, input bit expect_pass);
    bit seen = 0;
    drive(1'b1);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pin_out != '0) seen = 1;
    end
    drive(1'b0);
    for (int i = 0; i < mon; i++) begin
      @(negedge clk);
      if (pin_out != '0) seen = 1;
    end
    check(tag, {NUM_IN{seen}}, {NUM_IN{expect_pass}});
    check(tag, pin_out, '0);
  endtask

  task automatic configure(input logic en, input logic [1:0] m, input logic [15:0] d, input logic [15:0] c);
    cfg_enable = en; cfg_mode = m; cfg_div = d; cfg_count = c;
    wait_n(4);
  endtask

  task automatic t_reset;
    drive(1'b0);
    rst_n = 1'b0;
    wait_n(3);
    check("R7 reset", pin_out, '0);
    rst_n = 1'b1;
    wait_n(2);
    check("R7 reset", pin_out, '0);
    drive(1'b1);
    wait_n(2);
    check("R7 bypass", pin_out, '0);
    wait_n(1);
    check("R7 bypass", pin_out, '1);
    drive(1'b0);
    wait_n(3);
    check("R7 bypass", pin_out, '0);
  endtask

  task automatic t_custom_glitch;
    configure(1'b1, 2'd3, 16'd1, 16'd5);
    drive(1'b1); wait_n(2); drive(1'b0); wait_n(1);
    drive(1'b1); wait_n(4); drive(1'b0); wait_n(1);
    drive(1'b1); wait_n(3); drive(1'b0); wait_n(8);
    check("R1 glitches", pin_out, '0);
    drive(1'b1);
    wait_n(6);
    check("R1 before Nth", pin_out, '0);
    wait_n(1);
    check("R1 at Nth", pin_out, '1);
    drive(1'b0);
    wait_n(6);
    check("R2 fall before", pin_out, '1);
    wait_n(1);
    check("R2 fall at Nth", pin_out, '0);
  endtask

  task automatic t_independent;
    pin_in = 2'b01;
    wait_n(7);
    check("R9 per bit", pin_out, 2'b01);
    pin_in = 2'b10;
    wait_n(7);
    check("R9 per bit", pin_out, 2'b10);
    drive(1'b0);
    wait_n(8);
  endtask

  task automatic t_fast;
    configure(1'b1, 2'd0, 16'd0, 16'd0);
    pulse("R3 8 blocked", 8, 30, 1'b0);
    pulse("R3 9 passes", 9, 30, 1'b1);
  endtask

  task automatic t_mid;
    configure(1'b1, 2'd1, 16'd0, 16'd0);
    pulse("R4 511 blocked", 511, 1100, 1'b0);
    pulse("R4 512 passes", 512, 1100, 1'b1);
  endtask

  task automatic t_slow;
    configure(1'b1, 2'd2, 16'd0, 16'd0);
    drive(1'b1);
    wait_n(255 * HDIV + 2);
    check("R5 rise early", pin_out, '0);
    wait_n(HDIV);
    check("R5 rise late", pin_out, '1);
    drive(1'b0);
    wait_n(255 * HDIV + 2);
    check("R5 fall early", pin_out, '1);
    wait_n(HDIV);
    check("R5 fall late", pin_out, '0);
    wait_n(8);
    pulse("R5 short blocked", 255 * HDIV, 2 * 256 * HDIV + 10, 1'b0);
    pulse("R5 full passes", 256 * HDIV, 2 * 256 * HDIV + 10, 1'b1);
  endtask

  task automatic t_custom_div;
    configure(1'b1, 2'd3, 16'd3, 16'd4);
    drive(1'b1);
    wait_n(3 * 3 + 2);
    check("R6 window early", pin_out, '0);
    wait_n(3);
    check("R6 window late", pin_out, '1);
    drive(1'b0);
    wait_n(20);
    configure(1'b1, 2'd3, 16'd0, 16'd0);
    drive(1'b1);
    wait_n(2);
    check("R6 zero fields", pin_out, '0);
    wait_n(1);
    check("R6 zero fields", pin_out, '1);
    drive(1'b0);
    wait_n(6);
  endtask

  task automatic t_reload;
    cfg_enable = 1'b0;
    drive(1'b1);
    wait_n(4);
    check("R8 pre enable", pin_out, '1);
    cfg_enable = 1'b1; cfg_mode = 2'd3; cfg_div = 16'd1; cfg_count = 16'd5;
    for (int i = 0; i < 4; i++) begin
      wait_n(1);
      check("R8 no false edge", pin_out, '1);
    end
    drive(1'b0);
    wait_n(4);
    check("R8 mid run", pin_out, '1);
    cfg_count = 16'd6;
    wait_n(1);
    check("R8 reload loads level", pin_out, '0);
    cfg_enable = 1'b0;
    drive(1'b1);
    wait_n(3);
    check("R7 bypass again", pin_out, '1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_custom_glitch();
    t_independent();
    t_fast();
    t_mid();
    t_slow();
    t_custom_div();
    t_reload();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule